// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block turns one fast master clock into the timing of a raster video system. A prescaler gives a one-cycle enable every few master cycles. That enable is the shared system and pixel rate, and the CPU and the video fetch both use it. A horizontal counter steps on each enable and wraps at a fixed line length. Its value is sent out as the low video address, and it also yields an active-low flag for the visible part of the line. A line counter steps once per scanline, at the moment the visible part ends. Its value is sent out as the high video address, and it defines a vertical sync window at the top of the frame.

The horizontal sync pulse is decoded from the horizontal count, and composite sync is the exclusive-OR of horizontal and vertical sync. Inside the vertical sync window the horizontal pulse is moved earlier by a fixed shift. Because the pulse is inverted there by the XOR, this keeps its trailing edge, which a display locks on, at the same position in every line. The line length, visible width, pulse position, shift, frame length and vertical window are all parameters. The same block therefore covers both a 98-cycle line with the pulse at 72 and a 112-cycle line with the pulse at 88.

Top module: `vsync_timing`

## Requirements
- R1: `sysEn` is high for exactly one master cycle out of every PRESCALE. The first pulse comes in the PRESCALE-th cycle after reset is released.
- R2: `hAddr` advances by one in each cycle that follows an enable. It counts 0 to H_TOTAL-1 and then returns to 0. It holds in all other cycles.
- R3: `lineActiveN` is 0 while `hAddr` < H_ACTIVE and 1 while `hAddr` >= H_ACTIVE.
- R4: Outside vertical sync, `hSync` is 1 exactly when `hAddr` is in HSYNC_START to HSYNC_START+HSYNC_WIDTH-1 (72 to 79 by default).
- R5: While `vSync` is 1, `hSync` is 1 exactly when `hAddr` is in HSYNC_START-HSYNC_SHIFT to HSYNC_START-HSYNC_SHIFT+HSYNC_WIDTH-1 (64 to 71 by default).
- R6: `vAddr` advances by one on the enable where `hAddr` goes from H_ACTIVE-1 to H_ACTIVE. It returns to 0 after V_TOTAL-1 and holds otherwise.
- R7: `vSync` is 1 exactly when `vAddr` < VSYNC_LINES.
- R8: `cSync` equals `hSync` XOR `vSync` in every cycle.
- R9: A synchronous active-high `rst` clears the prescaler and both counters. In the cycle after it, `hAddr`=0, `vAddr`=0, `sysEn`=0, `lineActiveN`=0, `hSync`=0, `vSync`=1 and `cSync`=1.
- R10: With H_TOTAL=112 and HSYNC_START=88, the line wraps after count 111. `hSync` then covers 88 to 95 outside vertical sync and 80 to 87 inside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sysEn | output | 1 | System/pixel clock enable, one master cycle wide |
| hAddr | output | HW | Horizontal count, low video address |
| vAddr | output | VW | Line count, high video address |
| lineActiveN | output | 1 | Low during the visible part of a line |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| cSync | output | 1 | Composite sync, hSync XOR vSync |

## Verification
The bench sweeps more than two full frames in each of two configurations: a 98-cycle line with a short frame, and a 112-cycle line. In every master cycle it compares every output against values derived arithmetically from the number of cycles since reset. A design that failed to shift the pulse in the vertical window would show `hSync` at 72 to 79 during lines 0 to VSYNC_LINES-1. A design that stepped the line counter at the line wrap instead of at the end of the visible part would change `vAddr` 34 counts late. An off-by-one wrap at 97/98, at 111/112 or at the last line would drift against the expected counts within one line or one frame. A second reset in the middle of the run checks that every counter clears, not only the prescaler.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  // strobes sent from control to datapath each master cycle
  typedef struct packed {
    logic tick;       // system enable
    logic hWrap;      // last count of the line, with tick
    logic lineEnd;    // visible part ends, with tick
    logic frameWrap;  // last line of the frame, with lineEnd
  } strobes_t;
endpackage

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import vsync_pkg::*;
#(
  parameter int PRESCALE = 16,
  parameter int H_TOTAL  = 98,
  parameter int H_ACTIVE = 64,
  parameter int V_TOTAL  = 312,
  parameter int HW       = 7,
  parameter int VW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hCount,
  input  logic [VW-1:0] vCount,
  output strobes_t      stb
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] P_LAST   = PW'(PRESCALE - 1);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] ACT_LAST = HW'(H_ACTIVE - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);

  logic [PW-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else if (preCnt == P_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    stb.tick      = (preCnt == P_LAST);
    stb.hWrap     = stb.tick && (hCount == H_LAST);
    stb.lineEnd   = stb.tick && (hCount == ACT_LAST);
    stb.frameWrap = stb.lineEnd && (vCount == V_LAST);
  end

  generate
    if (PRESCALE > 1) begin : g_spacing
      assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        stb.tick |=> !stb.tick);
    end
  endgenerate
endmodule

// File: rtl/sync_datapath.sv
module sync_datapath
  import vsync_pkg::*;
#(
  parameter int H_ACTIVE    = 64,
  parameter int HSYNC_START = 72,
  parameter int HSYNC_WIDTH = 8,
  parameter int HSYNC_SHIFT = 8,
  parameter int V_TOTAL     = 312,
  parameter int VSYNC_LINES = 4,
  parameter int HW          = 7,
  parameter int VW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  strobes_t      stb,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          lineActiveN,
  output logic          hSync,
  output logic          vSync,
  output logic          cSync
);
  localparam int HS_EARLY = HSYNC_START - HSYNC_SHIFT;
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) hCount <= '0;
    else if (stb.hWrap) hCount <= '0;
    else if (stb.tick) hCount <= hCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) vCount <= '0;
    else if (stb.frameWrap) vCount <= '0;
    else if (stb.lineEnd) vCount <= vCount + 1'b1;
  end

  logic inNormal, inEarly;
  always_comb begin
    lineActiveN = (int'(hCount) >= H_ACTIVE);
    vSync       = (int'(vCount) < VSYNC_LINES);
    inNormal    = (int'(hCount) >= HSYNC_START) && (int'(hCount) < HSYNC_START + HSYNC_WIDTH);
    inEarly     = (int'(hCount) >= HS_EARLY) && (int'(hCount) < HS_EARLY + HSYNC_WIDTH);
    hSync       = vSync ? inEarly : inNormal;
    cSync       = hSync ^ vSync;
  end

  assert_h_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    stb.hWrap |=> (hCount == '0));
  assert_h_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.tick |=> $stable(hCount));
  assert_line_step_R6: assert property (@(posedge clk) disable iff (rst)
    stb.lineEnd |=> (vCount == (($past(vCount) == V_LAST) ? '0 : $past(vCount) + 1'b1)));
  assert_v_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !stb.lineEnd |=> $stable(vCount));
  assert_vsync_top_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(vSync) |-> (vCount == '0));
  assert_hsync_blank_R4: assert property (@(posedge clk) disable iff (rst)
    hSync |-> lineActiveN);
endmodule

// File: rtl/vsync_timing.sv
module vsync_timing
  import vsync_pkg::*;
#(
  parameter int PRESCALE    = 16,
  parameter int H_TOTAL     = 98,
  parameter int H_ACTIVE    = 64,
  parameter int HSYNC_START = 72,
  parameter int HSYNC_WIDTH = 8,
  parameter int HSYNC_SHIFT = 8,
  parameter int V_TOTAL     = 312,
  parameter int VSYNC_LINES = 4,
  parameter int HW          = $clog2(H_TOTAL),
  parameter int VW          = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          sysEn,
  output logic [HW-1:0] hAddr,
  output logic [VW-1:0] vAddr,
  output logic          lineActiveN,
  output logic          hSync,
  output logic          vSync,
  output logic          cSync
);
  strobes_t stb;

  sync_ctrl #(
    .PRESCALE(PRESCALE), .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE),
    .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) uCtrl (
    .clk(clk), .rst(rst), .hCount(hAddr), .vCount(vAddr), .stb(stb)
  );

  sync_datapath #(
    .H_ACTIVE(H_ACTIVE), .HSYNC_START(HSYNC_START), .HSYNC_WIDTH(HSYNC_WIDTH),
    .HSYNC_SHIFT(HSYNC_SHIFT), .V_TOTAL(V_TOTAL), .VSYNC_LINES(VSYNC_LINES),
    .HW(HW), .VW(VW)
  ) uData (
    .clk(clk), .rst(rst), .stb(stb), .hCount(hAddr), .vCount(vAddr),
    .lineActiveN(lineActiveN), .hSync(hSync), .vSync(vSync), .cSync(cSync)
  );

  assign sysEn = stb.tick;

  assert_csync_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $changed(cSync) |-> ($changed(hSync) || $changed(vSync)));
endmodule

// File: tb/sim_vsync_timing.sv
module sim_vsync_timing;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // u0: 98-cycle line, short frame; u1: 112-cycle line variant
  logic s0, l0, h0, v0, c0;
  logic [6:0] ha0;
  logic [3:0] va0;
  logic s1, l1, h1, v1, c1;
  logic [6:0] ha1;
  logic [2:0] va1;

  vsync_timing #(.PRESCALE(4), .H_TOTAL(98), .H_ACTIVE(64), .HSYNC_START(72),
    .V_TOTAL(10), .VSYNC_LINES(3)) u0 (
    .clk(clk), .rst(rst), .sysEn(s0), .hAddr(ha0), .vAddr(va0),
    .lineActiveN(l0), .hSync(h0), .vSync(v0), .cSync(c0));

  vsync_timing #(.PRESCALE(2), .H_TOTAL(112), .H_ACTIVE(64), .HSYNC_START(88),
    .V_TOTAL(6), .VSYNC_LINES(2)) u1 (
    .clk(clk), .rst(rst), .sysEn(s1), .hAddr(ha1), .vAddr(va1),
    .lineActiveN(l1), .hSync(h1), .vSync(v1), .cSync(c1));

  task automatic check(string req, int got, int exp, int n);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, n, got, exp);
    end
  endtask

  // expected outputs from the cycle count since reset
  task automatic model(input int n, input int p, input int ht, input int act,
                       input int vt, input int vsl, input int hs,
                       output int en, output int h, output int v, output int la,
                       output int hsy, output int vsy, output int cs);
    int t, lines, st;
    t = n / p;
    en = ((n % p) == p - 1) ? 1 : 0;
    h = t % ht;
    lines = (t >= act) ? ((t - act) / ht + 1) : 0;
    v = lines % vt;
    la = (h >= act) ? 1 : 0;
    vsy = (v < vsl) ? 1 : 0;
    st = vsy ? hs - 8 : hs;
    hsy = (h >= st && h < st + 8) ? 1 : 0;
    cs = hsy ^ vsy;
  endtask

  task automatic sample(int n);
    int en, h, v, la, hsy, vsy, cs;
    model(n, 4, 98, 64, 10, 3, 72, en, h, v, la, hsy, vsy, cs);
    check("R1 sysEn", s0, en, n);
    check("R2 hAddr", ha0, h, n);
    check("R6 vAddr", va0, v, n);
    check("R3 lineActiveN", l0, la, n);
    check(vsy ? "R5 hSync early" : "R4 hSync", h0, hsy, n);
    check("R7 vSync", v0, vsy, n);
    check("R8 cSync", c0, cs, n);
    model(n, 2, 112, 64, 6, 2, 88, en, h, v, la, hsy, vsy, cs);
    check("R10 sysEn", s1, en, n);
    check("R10 hAddr", ha1, h, n);
    check("R10 vAddr", va1, v, n);
    check("R10 lineActiveN", l1, la, n);
    check("R10 hSync", h1, hsy, n);
    check("R10 vSync", v1, vsy, n);
    check("R10 cSync", c1, cs, n);
  endtask

  task automatic run(int cycles);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9: reset state before any counting edge
    check("R9 reset hAddr", ha0, 0, 0);
    check("R9 reset vAddr", va0, 0, 0);
    check("R9 reset sysEn", s0, 0, 0);
    check("R9 reset lineActiveN", l0, 0, 0);
    check("R9 reset hSync", h0, 0, 0);
    check("R9 reset vSync", v0, 1, 0);
    check("R9 reset cSync", c0, 1, 0);
    for (int n = 1; n <= cycles; n++) begin
      @(negedge clk);
      sample(n);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run(8200);
    run(1500);   // second reset mid-run, counters not at zero
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule